// File: doc/BRIEF.md
# Timer Compare Channel with Waveform Output

This block is one compare channel hung off a shared free-running timer count. Every cycle it checks the count against its own 16-bit compare value. On a match it raises a sticky compare flag, stores the synchronized level of an external capture pin, and applies one of eight output rules to a single waveform pin. The rules mix this channel's match with the period-limit match that channel zero broadcasts, so a pulse-width-modulated output runs with no software involvement once the compare value and the mode are set.

The waveform pin is held in a two-state machine with states PIN_LO and PIN_HI. The transitions are named by the action that causes them: SET (to PIN_HI), RESET (to PIN_LO) and TOGGLE (to the other state). In level mode the pin shows a software level directly, and the state register follows that level so that a later mode change starts from it (transition FOLLOW). The flag is cleared either by a local clear strobe or by an acknowledge from an interrupt vector block.

Top module: `ccm_channel`

## Requirements
- R1: While rst_n is low and right after it is released, wave_out, cmp_flag and cap_held are all 0.
- R2: On every clock edge at which tmr_count equals cmp_val, cmp_flag becomes 1 and stays 1 until it is cleared.
- R3: At an edge with no match, flag_clr or flag_ack at 1 clears cmp_flag to 0; if a match happens at the same edge, the flag is set and the strobes are ignored.
- R4: cap_pin goes through a two-stage synchronizer; at a match edge, cap_held takes the synchronizer output, and at other edges it holds its value.
- R5: out_mode selects the pin rule, applied at the clock edge: 001 SET on match; 010 TOGGLE on match, RESET on limit; 011 SET on match, RESET on limit; 100 TOGGLE on match; 101 RESET on match; 110 TOGGLE on match, SET on limit; 111 RESET on match, SET on limit. At an edge with neither event the pin does not change.
- R6: With out_mode 000, wave_out equals sw_level with no clock delay.
- R7: When the match and lim_hit occur at the same edge, the limit action wins in modes 010, 011, 110 and 111; modes 001, 100 and 101 ignore lim_hit.
- R8: In mode 111 with a period of N counts (limit at N-1) and the compare value at N/2-1, the pin is high for N/2 cycles and low for N/2 cycles of each period.
- R9: In mode 000 the pin state follows sw_level at each edge, so a switch to another mode starts from the last sampled software level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tmr_count | input | 16 | Shared timer count |
| lim_hit | input | 1 | Period-limit equality event from channel zero |
| cmp_val | input | 16 | Compare value of this channel |
| out_mode | input | 3 | Output rule select |
| sw_level | input | 1 | Software level for mode 000 |
| cap_pin | input | 1 | Asynchronous capture input |
| flag_clr | input | 1 | Local flag clear strobe |
| flag_ack | input | 1 | Flag acknowledge from the vector block |
| wave_out | output | 1 | Waveform pin |
| cmp_flag | output | 1 | Sticky compare flag |
| cap_held | output | 1 | Capture level latched at the last match |

## Verification
The assertions take lim_hit as a one-cycle event that the bench may raise at any cycle, including cycles that also carry this channel's match, and they take out_mode as stable across each edge it is sampled at. The bench changes every input only on the falling edge, keeps the random count and compare value in a small range so that matches, limit hits and coincident events are frequent, and sets cap_pin freely because the synchronizer is part of the expected-value model. Directed cases add the coincident-event precedence, the flag clear/set race and a full 1200-count PWM period.

// File: rtl/ccm_pkg.sv
package ccm_pkg;
    typedef enum logic [2:0] {
        OM_LEVEL   = 3'd0,
        OM_SET     = 3'd1,
        OM_TOG_RST = 3'd2,
        OM_SET_RST = 3'd3,
        OM_TOG     = 3'd4,
        OM_RST     = 3'd5,
        OM_TOG_SET = 3'd6,
        OM_RST_SET = 3'd7
    } out_mode_e;

    typedef enum logic {
        PIN_LO = 1'b0,
        PIN_HI = 1'b1
    } pin_e;
endpackage

// File: rtl/ccm_sync.sv
module ccm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst_n)      chain[i] <= 1'b0;
                else if (i == 0) chain[i] <= d;
                else             chain[i] <= chain[(i == 0) ? 0 : i-1];
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/ccm_match.sv
module ccm_match #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] count,
    input  logic [CW-1:0] cmp,
    input  logic          cap_s,
    input  logic          clr,
    input  logic          ack,
    output logic          eq,
    output logic          flag,
    output logic          cap_held
);
    assign eq = (count == cmp);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag     <= 1'b0;
            cap_held <= 1'b0;
        end else begin
            if (eq)              flag <= 1'b1;
            else if (clr || ack) flag <= 1'b0;
            if (eq) cap_held <= cap_s;
        end
    end

    assert_flag_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (count == cmp) |=> flag);
    assert_flag_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr && !ack) |=> flag);
    assert_cap_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (count != cmp) |=> $stable(cap_held));
endmodule

// File: rtl/ccm_wave.sv
module ccm_wave
    import ccm_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  out_mode_e mode,
    input  logic      eq,
    input  logic      lim,
    input  logic      sw,
    output logic      pin
);
    pin_e cur, nxt;

    always_comb begin
        nxt = cur;
        unique case (mode)
            OM_LEVEL:   nxt = sw ? PIN_HI : PIN_LO;
            OM_SET:     if (eq) nxt = PIN_HI;
            OM_TOG_RST: if (lim) nxt = PIN_LO; else if (eq) nxt = pin_e'(~cur);
            OM_SET_RST: if (lim) nxt = PIN_LO; else if (eq) nxt = PIN_HI;
            OM_TOG:     if (eq) nxt = pin_e'(~cur);
            OM_RST:     if (eq) nxt = PIN_LO;
            OM_TOG_SET: if (lim) nxt = PIN_HI; else if (eq) nxt = pin_e'(~cur);
            OM_RST_SET: if (lim) nxt = PIN_HI; else if (eq) nxt = PIN_LO;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur <= PIN_LO;
        else        cur <= nxt;
    end

    always_comb begin
        if (mode == OM_LEVEL) pin = sw;
        else                  pin = (cur == PIN_HI);
    end

    assert_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!eq && !lim && mode != OM_LEVEL) |=> $stable(cur));
    assert_lim_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (lim && (mode == OM_RST_SET || mode == OM_TOG_SET)) |=> (cur == PIN_HI));
    assert_lim_rst_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (lim && (mode == OM_SET_RST || mode == OM_TOG_RST)) |=> (cur == PIN_LO));
endmodule

// File: rtl/ccm_channel.sv
module ccm_channel
    import ccm_pkg::*;
#(
    parameter int CW        = 16,
    parameter int SYNC_LEN  = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] tmr_count,
    input  logic          lim_hit,
    input  logic [CW-1:0] cmp_val,
    input  logic [2:0]    out_mode,
    input  logic          sw_level,
    input  logic          cap_pin,
    input  logic          flag_clr,
    input  logic          flag_ack,
    output logic          wave_out,
    output logic          cmp_flag,
    output logic          cap_held
);
    logic cap_s;
    logic eq;

    ccm_sync #(.STAGES(SYNC_LEN)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (cap_pin),
        .q     (cap_s)
    );

    ccm_match #(.CW(CW)) u_match (
        .clk      (clk),
        .rst_n    (rst_n),
        .count    (tmr_count),
        .cmp      (cmp_val),
        .cap_s    (cap_s),
        .clr      (flag_clr),
        .ack      (flag_ack),
        .eq       (eq),
        .flag     (cmp_flag),
        .cap_held (cap_held)
    );

    ccm_wave u_wave (
        .clk   (clk),
        .rst_n (rst_n),
        .mode  (out_mode_e'(out_mode)),
        .eq    (eq),
        .lim   (lim_hit),
        .sw    (sw_level),
        .pin   (wave_out)
    );

    assert_mode0_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_mode == 3'd0) |-> (wave_out == sw_level));
endmodule

// File: tb/tb_ccm_channel.sv
module tb_ccm_channel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] b_count = '0;
    logic        b_lim = 1'b0;
    logic [15:0] b_cmp = 16'd100;
    logic [2:0]  b_mode = 3'd0;
    logic        b_sw = 1'b0;
    logic        b_cap = 1'b0;
    logic        b_clr = 1'b0;
    logic        b_ack = 1'b0;
    logic        wave_out, cmp_flag, cap_held;

    int tests = 0;
    int fails = 0;

    logic m_pin = 1'b0, m_flag = 1'b0, m_cap = 1'b0, m_s1 = 1'b0, m_s2 = 1'b0;

    always #10 clk = ~clk;

    ccm_channel dut (
        .clk(clk), .rst_n(rst_n), .tmr_count(b_count), .lim_hit(b_lim),
        .cmp_val(b_cmp), .out_mode(b_mode), .sw_level(b_sw), .cap_pin(b_cap),
        .flag_clr(b_clr), .flag_ack(b_ack),
        .wave_out(wave_out), .cmp_flag(cmp_flag), .cap_held(cap_held)
    );

    function automatic logic next_pin(logic [2:0] md, logic cur, logic e, logic l, logic s);
        case (md)
            3'd0: return s;
            3'd1: return e ? 1'b1 : cur;
            3'd2: return l ? 1'b0 : (e ? ~cur : cur);
            3'd3: return l ? 1'b0 : (e ? 1'b1 : cur);
            3'd4: return e ? ~cur : cur;
            3'd5: return e ? 1'b0 : cur;
            3'd6: return l ? 1'b1 : (e ? ~cur : cur);
            default: return l ? 1'b1 : (e ? 1'b0 : cur);
        endcase
    endfunction

    function automatic logic exp_wave();
        return (b_mode == 3'd0) ? b_sw : m_pin;
    endfunction

    task automatic chk(string req, logic act, logic exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b (t=%0t)", req, act, exp, $time);
        end
    endtask

    // one clock: model updates at the edge, outputs compared at the falling edge
    task automatic cyc(bit check_all);
        logic e;
        @(posedge clk);
        e = (b_count == b_cmp);
        if (!rst_n) begin
            m_pin = 0; m_flag = 0; m_cap = 0; m_s1 = 0; m_s2 = 0;
        end else begin
            m_pin = next_pin(b_mode, m_pin, e, b_lim, b_sw);
            if (e) m_flag = 1'b1; else if (b_clr || b_ack) m_flag = 1'b0;
            if (e) m_cap = m_s2;
            m_s2 = m_s1;
            m_s1 = b_cap;
        end
        @(negedge clk);
        if (check_all) begin
            chk("R5 pin", wave_out, exp_wave());
            chk("R2 flag", cmp_flag, m_flag);
            chk("R4 cap", cap_held, m_cap);
        end
    endtask

    task automatic idle_in();
        b_lim = 0; b_clr = 0; b_ack = 0; b_count = 16'd50; b_cmp = 16'd100;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int hi_cnt;
        logic [31:0] r;
        r = $urandom(32'd2024);

        // R1: reset state
        b_cap = 1; b_sw = 1; b_mode = 3'd7;
        repeat (3) cyc(1'b0);
        chk("R1 wave in reset", wave_out, 1'b0);
        chk("R1 flag in reset", cmp_flag, 1'b0);
        chk("R1 cap in reset", cap_held, 1'b0);
        rst_n = 1'b1; b_cap = 0; b_sw = 0;
        idle_in();
        cyc(1'b0);
        chk("R1 wave after release", wave_out, 1'b0);
        chk("R1 flag after release", cmp_flag, 1'b0);

        // R6: mode 000 is combinational
        b_mode = 3'd0; b_sw = 1; #1;
        chk("R6 level immediate high", wave_out, 1'b1);
        b_sw = 0; #1;
        chk("R6 level immediate low", wave_out, 1'b0);

        // R9: leave mode 000 from a high level, no events
        b_sw = 1; cyc(1'b1);
        b_mode = 3'd4; b_sw = 0; cyc(1'b1);
        chk("R9 toggle mode starts from last level", wave_out, 1'b1);

        // R3: clear/ack and race with a match
        b_count = 16'd100; cyc(1'b1); b_count = 16'd50;
        chk("R2 flag set on match", cmp_flag, 1'b1);
        cyc(1'b1);
        chk("R2 flag sticky", cmp_flag, 1'b1);
        b_clr = 1; cyc(1'b1); b_clr = 0;
        chk("R3 clear strobe", cmp_flag, 1'b0);
        b_count = 16'd100; cyc(1'b1);
        b_ack = 1; b_count = 16'd100; cyc(1'b1);
        chk("R3 match wins over ack", cmp_flag, 1'b1);
        b_count = 16'd50; cyc(1'b1); b_ack = 0;
        chk("R3 ack clears", cmp_flag, 1'b0);

        // R4: synchronized capture at match
        b_cap = 1; repeat (3) cyc(1'b1);
        b_count = 16'd100; cyc(1'b1); b_count = 16'd50;
        chk("R4 cap latched high", cap_held, 1'b1);
        b_cap = 0; repeat (3) cyc(1'b1);
        chk("R4 cap held without match", cap_held, 1'b1);

        // R7: coincident events
        b_mode = 3'd3; b_count = 16'd100; b_lim = 1; cyc(1'b1);
        chk("R7 set/reset limit wins", wave_out, 1'b0);
        b_mode = 3'd7; cyc(1'b1);
        chk("R7 reset/set limit wins", wave_out, 1'b1);
        b_mode = 3'd5; cyc(1'b1);
        chk("R7 reset mode ignores limit", wave_out, 1'b0);
        b_mode = 3'd1; b_count = 16'd50; cyc(1'b1);
        chk("R7 set mode ignores lone limit", wave_out, 1'b0);
        b_mode = 3'd6; b_count = 16'd100; cyc(1'b1);
        chk("R7 toggle/set limit wins", wave_out, 1'b1);
        idle_in();

        // random mix, all modes
        for (int i = 0; i < 4000; i++) begin
            if (($urandom % 16) == 0) b_mode = 3'($urandom % 8);
            b_cmp   = 16'($urandom % 6);
            b_count = 16'($urandom % 6);
            b_lim   = (($urandom % 4) == 0);
            b_sw    = 1'($urandom);
            b_cap   = 1'($urandom);
            b_clr   = (($urandom % 5) == 0);
            b_ack   = (($urandom % 7) == 0);
            cyc(1'b1);
        end
        idle_in();

        // R8: 1200-count period, compare at 599, reset/set mode
        b_mode = 3'd7; b_cmp = 16'd599;
        for (int p = 0; p < 2; p++) begin
            hi_cnt = 0;
            for (int c = 0; c < 1200; c++) begin
                b_count = 16'(c);
                b_lim = (c == 1199);
                cyc(1'b0);
                if (wave_out) hi_cnt++;
            end
            if (p == 1) begin
                tests++;
                if (hi_cnt != 600) begin
                    fails++;
                    $display("FAIL R8 high cycles: actual %0d expected 600", hi_cnt);
                end
            end
        end
        b_count = 16'd0; b_lim = 0; cyc(1'b0);
        chk("R8 high after period start", wave_out, 1'b1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule